// File: doc/BRIEF.md
# Channelized Segmented Receive Frame Monitor

The block watches a receive data bus that is cut into twelve 16-byte segments. On every cycle where the bus is valid, the whole bus belongs to one channel, named by a 3-bit channel number. Each segment has its own enable, start marker, end marker and 4-bit empty-byte count. Six channels share the bus. Each channel keeps its own in-frame flag, running byte count and captured preamble. This state lives across cycles, so a frame can start on one cycle and end many cycles later, with cycles for other channels in between. One cycle may close an earlier frame, hold several whole frames, and open a new frame that runs on past the cycle.

For each frame that closes, the monitor produces an event that carries the channel, the byte length, the preamble captured at its start, and a runt tag. Events leave through a valid/ready stream that is fed by a small internal queue. When a cycle closes several frames, their events enter the queue in ascending segment order. The input bus has no back-pressure, because the monitor only observes it. While `ev_ready` is low, the head event stays on the output, unchanged. Events that find no free queue slot are dropped, and `err_drop` is raised. Protocol, channel and runt problems are reported as one-cycle error pulses.

Top module: `segstream_frame_mon`

## Requirements
- R1: Each enabled segment inside a frame adds 16 bytes, except the segment that carries the end marker. The end segment adds 16 minus its empty count, which is `seg_mty[4s+3:4s]` for segment s. A frame of four full segments therefore has a length of 64.
- R2: The preamble reported for a frame is the one present in the cycle of its start marker. A start in segments 0–3 takes `pre_grp0`, a start in segments 4–7 takes `pre_grp1`, and a start in segments 8–11 takes `pre_grp2`.
- R3: In-frame state and byte count are kept per channel (channel numbers 0–5). A frame interrupted by cycles for other channels resumes with its count intact.
- R4: When one cycle closes several frames, one event is produced per frame, in ascending segment order.
- R5: An event whose length is below 64 has `ev_runt`=1. `err_runt` pulses in the cycle after any input cycle that closes such a frame.
- R6: `err_proto` pulses in the cycle after an input cycle that has any of the following: a start while the channel is already in a frame (the old frame is abandoned and a new one begins); an enabled segment or end marker outside a frame (it is ignored); or a start or end marker on a disabled segment (it is ignored).
- R7: A valid cycle with a channel number of 6 or 7 pulses `err_chan` one cycle later and changes no channel state.
- R8: A cycle with `in_valid`=0 changes no state, whatever the segment inputs hold. A valid cycle with every enable low is legal idle and produces neither an event nor an error.
- R9: An event stays on the output stream, stable, while `ev_valid`=1 and `ev_ready`=0. The queue holds FIFO_DEPTH events. Events beyond the free slots are dropped, the highest segments first, and `err_drop` pulses one cycle later.
- R10: During reset, no channel is in a frame, the queue is empty, and `ev_valid` and every error output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Bus cycle carries channel data |
| in_chan | input | 3 | Channel number of this cycle |
| seg_ena | input | 12 | Per-segment enable |
| seg_sop | input | 12 | Per-segment start marker |
| seg_eop | input | 12 | Per-segment end marker |
| seg_mty | input | 48 | Per-segment empty byte count, 4 bits each |
| pre_grp0 | input | 56 | Preamble for starts in segments 0–3 |
| pre_grp1 | input | 56 | Preamble for starts in segments 4–7 |
| pre_grp2 | input | 56 | Preamble for starts in segments 8–11 |
| ev_valid | output | 1 | Frame event available |
| ev_ready | input | 1 | Consumer accepts the event |
| ev_chan | output | 3 | Channel of the event |
| ev_len | output | 16 | Frame length in bytes |
| ev_pre | output | 56 | Captured preamble |
| ev_runt | output | 1 | Frame shorter than 64 bytes |
| err_proto | output | 1 | Marker-ordering error pulse |
| err_chan | output | 1 | Illegal channel number pulse |
| err_runt | output | 1 | Runt frame pulse |
| err_drop | output | 1 | Event dropped for lack of queue space |

## Verification
Every result is due exactly one clock after the input edge that samples its cause. Each error flag is a one-cycle pulse in that cycle. An event pushed at that edge is on the output stream from that cycle on, provided no older event is still queued ahead of it. The bench drives each cycle's inputs on the falling edge. A behavioural model then advances its per-channel state and its event queue for that same rising edge. The outputs are compared 1 ns after the edge on every cycle, so every result is checked in the cycle it becomes due.

// File: rtl/segmon_pkg.sv
package segmon_pkg;
  localparam int SEG_N     = 12;
  localparam int SEG_BYTES = 16;
  localparam int MTY_W     = 4;
  localparam int CHAN_N    = 6;
  localparam int CH_W      = 3;
  localparam int LEN_W     = 16;
  localparam int PRE_W     = 56;
  localparam int MIN_LEN   = 64;
  localparam int GRP_SEGS  = 4;
  localparam int GRP_N     = SEG_N / GRP_SEGS;

  typedef struct packed {
    logic [CH_W-1:0]  chan;
    logic [LEN_W-1:0] len;
    logic [PRE_W-1:0] pre;
    logic             runt;
  } frame_evt_t;
endpackage

// File: rtl/segmon_scan.sv
// Walks the segments of one bus cycle in order and threads the channel's
// frame state through them.
module segmon_scan
  import segmon_pkg::*;
(
  input  logic [CH_W-1:0]              chan_i,
  input  logic                         inf_i,
  input  logic [LEN_W-1:0]             cnt_i,
  input  logic [PRE_W-1:0]             pre_i,
  input  logic [SEG_N-1:0]             ena_i,
  input  logic [SEG_N-1:0]             sop_i,
  input  logic [SEG_N-1:0]             eop_i,
  input  logic [SEG_N*MTY_W-1:0]       mty_i,
  input  logic [GRP_N-1:0][PRE_W-1:0]  lane_i,
  output logic                         inf_o,
  output logic [LEN_W-1:0]             cnt_o,
  output logic [PRE_W-1:0]             pre_o,
  output logic [SEG_N-1:0]             evt_vld_o,
  output frame_evt_t [SEG_N-1:0]       evt_o,
  output logic                         proto_err_o
);
  logic [PRE_W-1:0] seg_lane [SEG_N];

  // Each segment is tied to the preamble lane of its group.
  for (genvar s = 0; s < SEG_N; s++) begin : g_lane
    assign seg_lane[s] = lane_i[s / GRP_SEGS];
  end

  logic             inf;
  logic [LEN_W-1:0] cnt;
  logic [PRE_W-1:0] pre;
  logic [LEN_W-1:0] len;
  logic [MTY_W-1:0] mty;

  always_comb begin
    inf         = inf_i;
    cnt         = cnt_i;
    pre         = pre_i;
    len         = '0;
    mty         = '0;
    evt_vld_o   = '0;
    evt_o       = '0;
    proto_err_o = 1'b0;
    for (int s = 0; s < SEG_N; s++) begin
      mty = mty_i[s*MTY_W +: MTY_W];
      if (!ena_i[s]) begin
        // A marker on a disabled segment is ignored and flagged.
        if (sop_i[s] || eop_i[s]) proto_err_o = 1'b1;
      end else begin
        if (sop_i[s]) begin
          if (inf) proto_err_o = 1'b1;   // the old frame is abandoned
          inf = 1'b1;
          cnt = '0;
          pre = seg_lane[s];
        end
        if (!inf) begin
          proto_err_o = 1'b1;            // data outside a frame
        end else if (eop_i[s]) begin
          len          = cnt + LEN_W'(SEG_BYTES) - LEN_W'(mty);
          evt_vld_o[s] = 1'b1;
          evt_o[s]     = {chan_i, len, pre, (len < LEN_W'(MIN_LEN))};
          inf          = 1'b0;
          cnt          = '0;
        end else begin
          cnt = cnt + LEN_W'(SEG_BYTES);
        end
      end
    end
    inf_o = inf;
    cnt_o = cnt;
    pre_o = pre;
  end
endmodule

// File: rtl/segmon_chan_tab.sv
// Per-channel frame state: in-frame flag, running count, captured preamble.
module segmon_chan_tab
  import segmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_W-1:0]   sel_i,
  input  logic              wr_en_i,
  input  logic              wr_inf_i,
  input  logic [LEN_W-1:0]  wr_cnt_i,
  input  logic [PRE_W-1:0]  wr_pre_i,
  output logic              rd_inf_o,
  output logic [LEN_W-1:0]  rd_cnt_o,
  output logic [PRE_W-1:0]  rd_pre_o,
  output logic [CHAN_N-1:0] inf_vec_o
);
  logic [CHAN_N-1:0] inf_q;
  logic [LEN_W-1:0]  cnt_q [CHAN_N];
  logic [PRE_W-1:0]  pre_q [CHAN_N];

  for (genvar c = 0; c < CHAN_N; c++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        inf_q[c] <= 1'b0;
        cnt_q[c] <= '0;
        pre_q[c] <= '0;
      end else if (wr_en_i && sel_i == CH_W'(c)) begin
        inf_q[c] <= wr_inf_i;
        cnt_q[c] <= wr_cnt_i;
        pre_q[c] <= wr_pre_i;
      end
    end
  end

  always_comb begin
    rd_inf_o = 1'b0;
    rd_cnt_o = '0;
    rd_pre_o = '0;
    for (int c = 0; c < CHAN_N; c++) begin
      if (sel_i == CH_W'(c)) begin
        rd_inf_o = inf_q[c];
        rd_cnt_o = cnt_q[c];
        rd_pre_o = pre_q[c];
      end
    end
  end

  assign inf_vec_o = inf_q;

  // R8: a cycle that is not written leaves every in-frame flag alone
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(inf_q));
endmodule

// File: rtl/segmon_evq.sv
// Event queue that can take several events per cycle, in input-index order.
module segmon_evq
  import segmon_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int N_IN  = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_IN-1:0]           push_vld_i,
  input  frame_evt_t [N_IN-1:0]     push_data_i,
  output logic                      out_valid_o,
  input  logic                      out_ready_i,
  output frame_evt_t                out_data_o,
  output logic                      drop_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  frame_evt_t        mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  fill;
  int                rank [N_IN];
  int                total, free_n, acc_n;
  logic              pop;

  assign out_valid_o = (fill != '0);
  assign out_data_o  = mem[rd_ptr];
  assign pop         = out_valid_o && out_ready_i;

  always_comb begin
    total = 0;
    for (int k = 0; k < N_IN; k++) begin
      rank[k] = total;
      total   = total + int'(push_vld_i[k]);
    end
    free_n = DEPTH - int'(fill);
    acc_n  = (total < free_n) ? total : free_n;
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < N_IN; k++) begin
      if (push_vld_i[k] && rank[k] < free_n)
        mem[wr_ptr + PTR_W'(rank[k])] <= push_data_i[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      drop_o <= 1'b0;
    end else begin
      wr_ptr <= wr_ptr + PTR_W'(acc_n);
      rd_ptr <= rd_ptr + PTR_W'(pop);
      fill   <= fill + CNT_W'(acc_n) - CNT_W'(pop);
      drop_o <= (total > free_n);
    end
  end

  assert_fill_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
endmodule

// File: rtl/segstream_frame_mon.sv
module segstream_frame_mon
  import segmon_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [2:0]  in_chan,
  input  logic [11:0] seg_ena,
  input  logic [11:0] seg_sop,
  input  logic [11:0] seg_eop,
  input  logic [47:0] seg_mty,
  input  logic [55:0] pre_grp0,
  input  logic [55:0] pre_grp1,
  input  logic [55:0] pre_grp2,
  output logic        ev_valid,
  input  logic        ev_ready,
  output logic [2:0]  ev_chan,
  output logic [15:0] ev_len,
  output logic [55:0] ev_pre,
  output logic        ev_runt,
  output logic        err_proto,
  output logic        err_chan,
  output logic        err_runt,
  output logic        err_drop
);
  logic                       chan_ok, act;
  logic                       cur_inf, nxt_inf;
  logic [LEN_W-1:0]           cur_cnt, nxt_cnt;
  logic [PRE_W-1:0]           cur_pre, nxt_pre;
  logic [CHAN_N-1:0]          inf_vec;
  logic [SEG_N-1:0]           evt_vld;
  frame_evt_t [SEG_N-1:0]     evt;
  logic                       proto_now;
  logic [SEG_N-1:0]           runt_vec;
  frame_evt_t                 head;
  logic [GRP_N-1:0][PRE_W-1:0] lanes;

  assign chan_ok = (in_chan < CH_W'(CHAN_N));
  assign act     = in_valid && chan_ok;
  assign lanes   = {pre_grp2, pre_grp1, pre_grp0};

  segmon_chan_tab u_tab (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (in_chan),
    .wr_en_i   (act),
    .wr_inf_i  (nxt_inf),
    .wr_cnt_i  (nxt_cnt),
    .wr_pre_i  (nxt_pre),
    .rd_inf_o  (cur_inf),
    .rd_cnt_o  (cur_cnt),
    .rd_pre_o  (cur_pre),
    .inf_vec_o (inf_vec)
  );

  segmon_scan u_scan (
    .chan_i      (in_chan),
    .inf_i       (cur_inf),
    .cnt_i       (cur_cnt),
    .pre_i       (cur_pre),
    .ena_i       (seg_ena),
    .sop_i       (seg_sop),
    .eop_i       (seg_eop),
    .mty_i       (seg_mty),
    .lane_i      (lanes),
    .inf_o       (nxt_inf),
    .cnt_o       (nxt_cnt),
    .pre_o       (nxt_pre),
    .evt_vld_o   (evt_vld),
    .evt_o       (evt),
    .proto_err_o (proto_now)
  );

  segmon_evq #(.DEPTH(FIFO_DEPTH), .N_IN(SEG_N)) u_q (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_vld_i  (evt_vld & {SEG_N{act}}),
    .push_data_i (evt),
    .out_valid_o (ev_valid),
    .out_ready_i (ev_ready),
    .out_data_o  (head),
    .drop_o      (err_drop)
  );

  for (genvar s = 0; s < SEG_N; s++) begin : g_runt
    assign runt_vec[s] = evt_vld[s] && evt[s].runt;
  end

  assign ev_chan = head.chan;
  assign ev_len  = head.len;
  assign ev_pre  = head.pre;
  assign ev_runt = head.runt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_proto <= 1'b0;
      err_chan  <= 1'b0;
      err_runt  <= 1'b0;
    end else begin
      err_proto <= act && proto_now;
      err_chan  <= in_valid && !chan_ok;
      err_runt  <= act && (|runt_vec);
    end
  end

  assert_runt_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (ev_runt == (ev_len < LEN_W'(MIN_LEN))));

  assert_badchan_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !chan_ok) |=> $stable(inf_vec));

  assert_chan_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (ev_chan < CH_W'(CHAN_N)));
endmodule

// File: tb/test_segstream_frame_mon.sv
`timescale 1ns/1ps
module test_segstream_frame_mon;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  in_chan;
  logic [11:0] seg_ena, seg_sop, seg_eop;
  logic [47:0] seg_mty;
  logic [55:0] pre_grp0, pre_grp1, pre_grp2;
  logic        ev_valid, ev_ready, ev_runt;
  logic [2:0]  ev_chan;
  logic [15:0] ev_len;
  logic [55:0] ev_pre;
  logic        err_proto, err_chan, err_runt, err_drop;

  always #2 clk = ~clk;

  segstream_frame_mon #(.FIFO_DEPTH(DEPTH)) i_segstream_frame_mon (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
    .seg_ena(seg_ena), .seg_sop(seg_sop), .seg_eop(seg_eop), .seg_mty(seg_mty),
    .pre_grp0(pre_grp0), .pre_grp1(pre_grp1), .pre_grp2(pre_grp2),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_chan(ev_chan), .ev_len(ev_len),
    .ev_pre(ev_pre), .ev_runt(ev_runt), .err_proto(err_proto), .err_chan(err_chan),
    .err_runt(err_runt), .err_drop(err_drop)
  );

  typedef struct { int ch; int len; longint pre; bit runt; } ev_t;
  ev_t    q[$];
  int     m_inf [6];
  int     m_cnt [6];
  longint m_pre [6];
  bit     x_proto, x_chan, x_runt, x_drop;
  int     checks = 0;
  int     fails  = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference for one rising edge.
  task automatic model();
    ev_t evs[$];
    int  space;
    bit  pop;
    int  c;
    pop   = ev_ready && (q.size() > 0);
    space = DEPTH - q.size();
    x_proto = 0; x_chan = 0; x_runt = 0;
    if (in_valid) begin
      if (in_chan > 3'd5) x_chan = 1;
      else begin
        c = int'(in_chan);
        for (int s = 0; s < 12; s++) begin
          bit en = seg_ena[s];
          bit so = seg_sop[s];
          bit eo = seg_eop[s];
          int mt = int'(seg_mty[4*s +: 4]);
          if (!en) begin
            if (so || eo) x_proto = 1;
          end else begin
            if (so) begin
              if (m_inf[c] != 0) x_proto = 1;
              m_inf[c] = 1;
              m_cnt[c] = 0;
              m_pre[c] = (s < 4) ? longint'(pre_grp0) :
                         (s < 8) ? longint'(pre_grp1) : longint'(pre_grp2);
            end
            if (m_inf[c] == 0) x_proto = 1;
            else if (eo) begin
              ev_t e;
              e.ch   = c;
              e.len  = (m_cnt[c] + 16 - mt) & 16'hffff;
              e.pre  = m_pre[c];
              e.runt = (e.len < 64);
              if (e.runt) x_runt = 1;
              evs.push_back(e);
              m_inf[c] = 0;
              m_cnt[c] = 0;
            end else m_cnt[c] = (m_cnt[c] + 16) & 16'hffff;
          end
        end
      end
    end
    x_drop = (evs.size() > space);
    if (pop) void'(q.pop_front());
    for (int k = 0; k < evs.size() && k < space; k++) q.push_back(evs[k]);
  endtask

  task automatic compare(string tag);
    chk(tag, "ev_valid", longint'(ev_valid), longint'(q.size() > 0));
    if (q.size() > 0) begin
      chk(tag, "ev_chan", longint'(ev_chan), longint'(q[0].ch));
      chk(tag, "ev_len",  longint'(ev_len),  longint'(q[0].len));
      chk(tag, "ev_pre",  longint'(ev_pre),  q[0].pre);
      chk(tag, "ev_runt", longint'(ev_runt), longint'(q[0].runt));
    end
    chk(tag, "err_proto", longint'(err_proto), longint'(x_proto));
    chk(tag, "err_chan",  longint'(err_chan),  longint'(x_chan));
    chk(tag, "err_runt",  longint'(err_runt),  longint'(x_runt));
    chk(tag, "err_drop",  longint'(err_drop),  longint'(x_drop));
  endtask

  task automatic step(string tag);
    model();
    @(posedge clk);
    #1;
    compare(tag);
    @(negedge clk);
  endtask

  task automatic clr(int ch);
    in_valid = 1'b1;
    in_chan  = 3'(ch);
    seg_ena  = '0;
    seg_sop  = '0;
    seg_eop  = '0;
    seg_mty  = '0;
  endtask

  task automatic put(int s, bit so, bit eo, int mt);
    seg_ena[s] = 1'b1;
    seg_sop[s] = so;
    seg_eop[s] = eo;
    seg_mty[4*s +: 4] = 4'(mt);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int c = 0; c < 6; c++) begin m_inf[c] = 0; m_cnt[c] = 0; m_pre[c] = 0; end
    x_proto = 0; x_chan = 0; x_runt = 0; x_drop = 0;
    rst_n = 1'b0; ev_ready = 1'b1;
    clr(0); in_valid = 1'b0;
    pre_grp0 = 56'h00A1A2A3A4A5A6;
    pre_grp1 = 56'h00B1B2B3B4B5B6;
    pre_grp2 = 56'h00C1C2C3C4C5C6;
    repeat (2) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10", "ev_valid",  longint'(ev_valid),  0);
    chk("R10", "err_proto", longint'(err_proto), 0);
    chk("R10", "err_chan",  longint'(err_chan),  0);
    chk("R10", "err_runt",  longint'(err_runt),  0);
    chk("R10", "err_drop",  longint'(err_drop),  0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1/R2: start in group 1, six full segments -> 96 bytes
    clr(0); put(6, 1, 0, 0);
    for (int s = 7; s < 11; s++) put(s, 0, 0, 0);
    put(11, 0, 1, 0);
    step("R1");
    // R1/R2: group 0 start, nine segments, last empty 3 -> 141 bytes
    clr(0); put(1, 1, 0, 0);
    for (int s = 2; s < 9; s++) put(s, 0, 0, 0);
    put(9, 0, 1, 3);
    step("R2");
    // R2: group 2 start, preamble changes before the end cycle
    clr(0); put(8, 1, 0, 0); put(9, 0, 0, 0); put(10, 0, 0, 0); put(11, 0, 0, 0);
    step("R2");
    pre_grp2 = 56'h00DEADBEEF0001;
    clr(0); put(0, 0, 1, 15);
    step("R2");

    // R3: channel 1 opens, channel 2 interleaves, channel 1 resumes
    clr(1); put(8, 1, 0, 0); put(9, 0, 0, 0); put(10, 0, 0, 0); put(11, 0, 0, 0);
    step("R3");
    // R4: three 64-byte frames in one cycle, ascending segment order
    clr(2);
    for (int f = 0; f < 3; f++) begin
      put(4*f, 1, 0, 0); put(4*f+1, 0, 0, 0); put(4*f+2, 0, 0, 0); put(4*f+3, 0, 1, 0);
    end
    step("R4");
    clr(1); put(0, 0, 0, 0); put(1, 0, 0, 0); put(2, 0, 0, 0); put(3, 0, 1, 5);
    step("R3");
    repeat (3) begin clr(0); in_valid = 1'b0; step("R4"); end

    // R5: runt 32, legal 64, runt 63 in one cycle
    clr(3); put(0, 1, 0, 0); put(1, 0, 1, 0);
    put(4, 1, 0, 0); put(5, 0, 0, 0); put(6, 0, 0, 0); put(7, 0, 1, 0);
    put(8, 1, 0, 0); put(9, 0, 0, 0); put(10, 0, 0, 0); put(11, 0, 1, 1);
    step("R5");

    // R8: valid low with a start present, then idle valid, then an end
    clr(4); put(0, 1, 0, 0); in_valid = 1'b0;
    step("R8");
    clr(4);
    step("R8");
    clr(4); put(0, 0, 1, 0);
    step("R8");

    // R7: illegal channel numbers
    clr(6); put(0, 1, 0, 0);
    step("R7");
    clr(7); put(0, 0, 1, 0);
    step("R7");

    // R6: marker on disabled segment, then double start, then stray end
    clr(5); seg_sop[2] = 1'b1;
    step("R6");
    clr(5); put(0, 1, 0, 0); put(1, 0, 0, 0);
    put(2, 1, 0, 0); put(3, 0, 0, 0); put(4, 0, 0, 0); put(5, 0, 1, 0);
    step("R6");
    clr(5); put(3, 0, 1, 0);
    step("R6");

    // R9: stall the output and overfill the queue
    repeat (8) begin clr(0); in_valid = 1'b0; step("R9"); end
    ev_ready = 1'b0;
    repeat (3) begin
      clr(0);
      for (int s = 0; s < 12; s++) put(s, 1, 1, s);
      step("R9");
    end
    repeat (2) begin clr(0); in_valid = 1'b0; step("R9"); end
    ev_ready = 1'b1;
    repeat (20) begin clr(0); in_valid = 1'b0; step("R9"); end

    // R3: random interleaving across channels with random back-pressure
    for (int n = 0; n < 400; n++) begin
      clr(int'($urandom % 8));
      in_valid = ($urandom % 8) != 0;
      ev_ready = ($urandom % 4) != 0;
      pre_grp0 = {$urandom, $urandom} & 56'hFFFFFFFFFFFFFF;
      pre_grp1 = {$urandom, $urandom} & 56'hFFFFFFFFFFFFFF;
      pre_grp2 = {$urandom, $urandom} & 56'hFFFFFFFFFFFFFF;
      for (int s = 0; s < 12; s++) begin
        seg_ena[s] = ($urandom % 5) != 0;
        seg_sop[s] = ($urandom % 6) == 0;
        seg_eop[s] = ($urandom % 5) == 0;
        seg_mty[4*s +: 4] = 4'($urandom % 16);
      end
      step("R3");
    end
    ev_ready = 1'b1;
    repeat (20) begin clr(0); in_valid = 1'b0; step("R3"); end

    summary();
    $finish;
  end
endmodule